// File: doc/BRIEF.md
# Serial Command and Address Register Port

This block is the control port of a record engine. An external microcontroller talks to it over a four-wire synchronous serial link: a serial clock, a data input, a data output and an active-low select. Each select-low frame carries one command. The command is a 4-bit opcode, followed by a 13-bit address operand for the two write commands, or by a readback on the data output for the two read commands.

The port holds the recording start address and the recording stop address and presents both to the record engine. It can also return the engine's memory address counter or its 4-bit status word. All serial lines are asynchronous to the system clock. They are synchronized and edge-detected inside the block, so the serial clock must run well below the system clock (each serial half period at least four system clocks).

Top module: `scmd_port`

## Requirements
- R1: Opcode 4'h6 followed by 13 operand bits (MSB first) loads the stop address with the full operand once the 13th bit has been received.
- R2: Opcode 4'h5 followed by 13 operand bits loads the start address with the operand's bits 12..4 and with bits 3..0 forced to zero.
- R3: After reset the start address is 13'h0000, the stop address is 13'h1FFF and the data output is low.
- R4: Both address registers keep their values until a complete new write to that register; an operand cut short by deselection leaves the register unchanged.
- R5: Opcode 4'h7 returns the 13-bit address counter MSB first, one bit per serial clock. The value is captured when the opcode completes, even while the status inputs show recording or pause in progress. The data output is low after the 13th bit.
- R6: Opcode 4'h8 returns the status word MSB first as {busy, paused, core-active, full} (bit 3 to bit 0), then holds the data output low.
- R7: Opcode 4'h7 issued after a completed start or stop write returns that just-written register value (aligned for the start address) instead of the counter. Further consecutive 4'h7 commands keep returning it. Decoding any other opcode clears this override.
- R8: Raising the select line drives the data output low and discards any partial shift. The next frame always begins with a fresh opcode.
- R9: The data input is sampled on the serial clock's rising edge. The data output changes only after a falling edge of the serial clock or on deselection, so it is stable across each rising edge.
- R10: An opcode other than 4'h5..4'h8 changes no register, and the data output stays low for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the microcontroller |
| sdi_i | input | 1 | Serial data into the block |
| sel_n_i | input | 1 | Active-low frame select |
| sdo_o | output | 1 | Serial readback data |
| addr_cnt_i | input | 13 | Memory address counter from the record engine |
| stat_busy_i | input | 1 | Status: record/playback running, including memory control time |
| stat_paused_i | input | 1 | Status: operation suspended by pause |
| stat_core_i | input | 1 | Status: record/playback running, data time only |
| stat_full_i | input | 1 | Status: operation ended at the last memory address |
| start_addr_o | output | 13 | Recording start address to the engine |
| stop_addr_o | output | 13 | Recording stop address to the engine |

## Verification
The bench writes a start operand with nonzero low bits, because a design that stores the raw operand would read back those bits. It issues the counter read right after each kind of write, repeats it, and then issues it again after a status read. A design with a missing override, an override that clears after one read, or an override that never clears returns the wrong source at one of those points. It cuts a stop operand short and changes the counter in the middle of a readback: a design that commits partial operands, or that shifts the live counter instead of a snapshot, returns corrupted values. It also checks that the line stays low after the last bit, under an unknown opcode, and across every rising edge.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    localparam int ADDR_W  = 13;
    localparam int OP_W    = 4;
    localparam int STAT_W  = 4;
    localparam int GRAN_W  = 4;
    localparam int CNT_W   = $clog2(ADDR_W + 1);

    localparam logic [ADDR_W-1:0] START_RST = '0;
    localparam logic [ADDR_W-1:0] STOP_RST  = '1;

    typedef enum logic [OP_W-1:0] {
        OP_SET_START = 4'h5,
        OP_SET_STOP  = 4'h6,
        OP_READ_CNT  = 4'h7,
        OP_READ_STAT = 4'h8
    } op_e;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_OPERAND,
        PH_DRAIN
    } phase_e;

    typedef struct packed {
        logic busy;
        logic paused;
        logic core;
        logic full;
    } status_t;

    typedef struct packed {
        logic              op_valid;
        logic [OP_W-1:0]   op;
        logic              wr_valid;
        logic              wr_is_stop;
        logic [ADDR_W-1:0] wr_data;
    } rx_evt_t;

    typedef struct packed {
        logic              load;
        logic [ADDR_W-1:0] data;
        logic [CNT_W-1:0]  len;
    } tx_req_t;

    function automatic logic [ADDR_W-1:0] align_start(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] mask;
        mask = '1;
        mask = mask << GRAN_W;
        return a & mask;
    endfunction

    function automatic logic is_write_op(input logic [OP_W-1:0] op);
        return (op == OP_SET_START) || (op == OP_SET_STOP);
    endfunction

endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_a,
    input  logic sdi_a,
    input  logic sel_n_a,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s,
    output logic active
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sdi_q;
    logic [STAGES-1:0] sel_q;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            sdi_q <= '0;
            sel_q <= '1;
            sck_d <= 1'b0;
        end else begin
            sck_q <= {sck_q[STAGES-2:0], sck_a};
            sdi_q <= {sdi_q[STAGES-2:0], sdi_a};
            sel_q <= {sel_q[STAGES-2:0], sel_n_a};
            sck_d <= sck_q[STAGES-1];
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_q[STAGES-1] & sck_d;
    assign sdi_s    = sdi_q[STAGES-1];
    assign active   = ~sel_q[STAGES-1];

endmodule

// File: rtl/scmd_rx.sv
module scmd_rx
    import scmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    rise,
    input  logic    sdi,
    output rx_evt_t evt
);
    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] shreg;
    logic [ADDR_W-1:0] shreg_nxt;
    logic              tgt_stop;

    assign shreg_nxt = {shreg[ADDR_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase    <= PH_OPCODE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tgt_stop <= 1'b0;
            evt      <= '0;
        end else begin
            evt.op_valid <= 1'b0;
            evt.wr_valid <= 1'b0;
            if (rise) begin
                case (phase)
                    PH_OPCODE: begin
                        shreg <= shreg_nxt;
                        if (bit_cnt == CNT_W'(OP_W - 1)) begin
                            evt.op_valid <= 1'b1;
                            evt.op       <= shreg_nxt[OP_W-1:0];
                            bit_cnt      <= '0;
                            tgt_stop     <= (shreg_nxt[OP_W-1:0] == OP_SET_STOP);
                            phase        <= is_write_op(shreg_nxt[OP_W-1:0]) ? PH_OPERAND : PH_DRAIN;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_OPERAND: begin
                        shreg <= shreg_nxt;
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            evt.wr_valid   <= 1'b1;
                            evt.wr_is_stop <= tgt_stop;
                            evt.wr_data    <= shreg_nxt;
                            phase          <= PH_DRAIN;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
        !(evt.op_valid && evt.wr_valid));

endmodule

// File: rtl/scmd_regs.sv
module scmd_regs
    import scmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic [ADDR_W-1:0] addr_cnt,
    input  status_t           status,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] stop_q,
    output tx_req_t           req
);
    logic [ADDR_W-1:0] last_wr;
    logic              ovr;
    logic [ADDR_W-1:0] stored;

    assign stored = evt.wr_is_stop ? evt.wr_data : align_start(evt.wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= START_RST;
            stop_q  <= STOP_RST;
            last_wr <= '0;
            ovr     <= 1'b0;
        end else if (evt.wr_valid) begin
            if (evt.wr_is_stop) stop_q <= stored;
            else                start_q <= stored;
            last_wr <= stored;
            ovr     <= 1'b1;
        end else if (evt.op_valid && evt.op != OP_READ_CNT) begin
            ovr <= 1'b0;
        end
    end

    always_comb begin
        req = '0;
        if (evt.op_valid) begin
            case (evt.op)
                OP_READ_CNT: begin
                    req.load = 1'b1;
                    req.data = ovr ? last_wr : addr_cnt;
                    req.len  = CNT_W'(ADDR_W);
                end
                OP_READ_STAT: begin
                    req.load = 1'b1;
                    req.data = {status, {(ADDR_W-STAT_W){1'b0}}};
                    req.len  = CNT_W'(STAT_W);
                end
                default: ;
            endcase
        end
    end

    assert_stop_load_R1: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_valid && evt.wr_is_stop) |=> stop_q == $past(evt.wr_data));

    assert_start_align_R2: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_valid && !evt.wr_is_stop) |=>
            (start_q[GRAN_W-1:0] == '0) && (start_q[ADDR_W-1:GRAN_W] == $past(evt.wr_data[ADDR_W-1:GRAN_W])));

    assert_reset_vals_R3: assert property (@(posedge clk)
        rst |=> (start_q == START_RST) && (stop_q == STOP_RST));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !evt.wr_valid |=> $stable(start_q) && $stable(stop_q));

endmodule

// File: rtl/scmd_tx.sv
module scmd_tx
    import scmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    fall,
    input  tx_req_t req,
    output logic    sdo
);
    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            shreg <= '0;
            left  <= '0;
            sdo   <= 1'b0;
        end else if (req.load) begin
            shreg <= req.data;
            left  <= req.len;
        end else if (fall) begin
            if (left != '0) begin
                sdo   <= shreg[ADDR_W-1];
                shreg <= {shreg[ADDR_W-2:0], 1'b0};
                left  <= left - 1'b1;
            end else begin
                sdo <= 1'b0;
            end
        end
    end

    assert_edge_only_R9: assert property (@(posedge clk) disable iff (rst)
        (sdo != $past(sdo)) |-> $past(fall || !active));

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sdo);

endmodule

// File: rtl/scmd_port.sv
module scmd_port
    import scmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              sel_n_i,
    output logic              sdo_o,
    input  logic [ADDR_W-1:0] addr_cnt_i,
    input  logic              stat_busy_i,
    input  logic              stat_paused_i,
    input  logic              stat_core_i,
    input  logic              stat_full_i,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [ADDR_W-1:0] stop_addr_o
);
    logic    sck_rise;
    logic    sck_fall;
    logic    sdi_s;
    logic    active;
    rx_evt_t evt;
    tx_req_t req;
    status_t status;

    assign status = '{busy: stat_busy_i, paused: stat_paused_i,
                      core: stat_core_i, full: stat_full_i};

    scmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_a    (sck_i),
        .sdi_a    (sdi_i),
        .sel_n_a  (sel_n_i),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s),
        .active   (active)
    );

    scmd_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .rise   (sck_rise),
        .sdi    (sdi_s),
        .evt    (evt)
    );

    scmd_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_cnt (addr_cnt_i),
        .status   (status),
        .start_q  (start_addr_o),
        .stop_q   (stop_addr_o),
        .req      (req)
    );

    scmd_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .fall   (sck_fall),
        .req    (req),
        .sdo    (sdo_o)
    );

endmodule

// File: tb/scmd_port_bench.sv
`timescale 1ns/1ps
module scmd_port_bench;

    localparam int H = 8;

    typedef struct packed {
        logic [3:0]  op;
        logic [12:0] arg;
        logic [12:0] cnt;
        logic [3:0]  st;
        logic [12:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'h7, 13'h0000, 13'h0ABC, 4'h0, 13'h0ABC},
        '{4'h8, 13'h0000, 13'h0000, 4'hA, 13'h000A},
        '{4'h5, 13'h1234, 13'h0000, 4'h0, 13'h1230},
        '{4'h7, 13'h0000, 13'h0F0F, 4'h0, 13'h1230},
        '{4'h7, 13'h0000, 13'h0F0F, 4'h0, 13'h1230},
        '{4'h6, 13'h0777, 13'h0000, 4'h0, 13'h0777},
        '{4'h7, 13'h0000, 13'h0001, 4'h0, 13'h0777},
        '{4'h8, 13'h0000, 13'h0000, 4'h5, 13'h0005},
        '{4'h7, 13'h0000, 13'h1555, 4'h0, 13'h1555},
        '{4'h5, 13'h1FFF, 13'h0000, 4'h0, 13'h1FF0},
        '{4'hA, 13'h1FFF, 13'h0000, 4'h0, 13'h1FF0},
        '{4'h7, 13'h0000, 13'h0002, 4'h0, 13'h0002}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdo;
    logic [12:0] cnt = '0;
    logic [3:0]  st = '0;
    logic [12:0] start_a;
    logic [12:0] stop_a;

    int n_run  = 0;
    int n_fail = 0;
    int unstable = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scmd_port u_scmd_port (
        .clk          (clk),
        .rst          (rst),
        .sck_i        (sck),
        .sdi_i        (sdi),
        .sel_n_i      (sel_n),
        .sdo_o        (sdo),
        .addr_cnt_i   (cnt),
        .stat_busy_i  (st[3]),
        .stat_paused_i(st[2]),
        .stat_core_i  (st[1]),
        .stat_full_i  (st[0]),
        .start_addr_o (start_a),
        .stop_addr_o  (stop_a)
    );

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic cycle(input logic b, output logic smp);
        sdi = b;
        wait_h();
        smp = sdo;
        sck = 1'b1;
        wait_h();
        if (sdo !== smp) unstable++;
        sck = 1'b0;
    endtask

    task automatic begin_frame();
        sel_n = 1'b0;
        wait_h();
    endtask

    task automatic end_frame();
        wait_h();
        sel_n = 1'b1;
        wait_h();
        wait_h();
    endtask

    task automatic send_bits(input logic [12:0] v, input int n);
        logic s;
        for (int i = n - 1; i >= 0; i--) cycle(v[i], s);
    endtask

    task automatic recv_bits(input int n, output logic [12:0] v, output logic tail);
        logic s;
        v = '0;
        for (int i = 0; i < n; i++) begin
            cycle(1'b0, s);
            v = {v[11:0], s};
        end
        cycle(1'b0, tail);
    endtask

    logic [12:0] rv;
    logic        tl;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        check("R3 start reset", start_a, 13'h0000);
        check("R3 stop reset", stop_a, 13'h1FFF);
        check("R3 sdo reset", {12'b0, sdo}, 13'h0);

        for (int k = 0; k < NV; k++) begin
            cnt = VECS[k].cnt;
            st  = VECS[k].st;
            begin_frame();
            send_bits({9'b0, VECS[k].op}, 4);
            case (VECS[k].op)
                4'h5: begin
                    send_bits(VECS[k].arg, 13);
                    end_frame();
                    check("R2 start write", start_a, VECS[k].exp);
                end
                4'h6: begin
                    send_bits(VECS[k].arg, 13);
                    end_frame();
                    check("R1 stop write", stop_a, VECS[k].exp);
                end
                4'h7: begin
                    recv_bits(13, rv, tl);
                    end_frame();
                    check("R5/R7 addr read", rv, VECS[k].exp);
                    check("R5 tail low", {12'b0, tl}, 13'h0);
                end
                4'h8: begin
                    recv_bits(4, rv, tl);
                    end_frame();
                    check("R6 status read", rv, VECS[k].exp);
                    check("R6 tail low", {12'b0, tl}, 13'h0);
                end
                default: begin
                    send_bits(VECS[k].arg, 13);
                    end_frame();
                    check("R10 unknown op start", start_a, VECS[k].exp);
                end
            endcase
        end

        // R4 and R8: truncated stop operand, then a fresh frame reads the live counter
        begin_frame();
        send_bits(13'h0006, 4);
        send_bits(13'h0055, 7);
        end_frame();
        check("R4 stop held after abort", stop_a, 13'h0777);
        check("R4 start held", start_a, 13'h1FF0);
        cnt = 13'h0C3A;
        begin_frame();
        send_bits(13'h0007, 4);
        recv_bits(13, rv, tl);
        end_frame();
        check("R8 fresh opcode after abort", rv, 13'h0C3A);

        // R5: counter captured at decode, during recording and pause flags
        st  = 4'b1100;
        cnt = 13'h1A5A;
        begin_frame();
        send_bits(13'h0007, 4);
        cnt = 13'h0001;
        recv_bits(13, rv, tl);
        end_frame();
        check("R5 snapshot while busy/paused", rv, 13'h1A5A);

        // R10: unknown opcode keeps DO low while master clocks on
        begin_frame();
        send_bits(13'h000F, 4);
        recv_bits(12, rv, tl);
        end_frame();
        check("R10 sdo low under unknown op", rv, 13'h0);
        check("R10 stop unchanged", stop_a, 13'h0777);

        // R8: deselect mid-readback drops DO
        cnt = 13'h1FFF;
        begin_frame();
        send_bits(13'h0007, 4);
        recv_bits(3, rv, tl);
        sel_n = 1'b1;
        wait_h();
        check("R8 sdo low after deselect", {12'b0, sdo}, 13'h0);
        wait_h();

        // R7: stop write then two reads return the written value
        begin_frame();
        send_bits(13'h0006, 4);
        send_bits(13'h0ACE, 13);
        end_frame();
        cnt = 13'h0000;
        begin_frame();
        send_bits(13'h0007, 4);
        recv_bits(13, rv, tl);
        end_frame();
        check("R7 override after stop write", rv, 13'h0ACE);

        check("R9 sdo stable across rising edges", unstable[12:0], 13'h0);

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule